// File: doc/BRIEF.md
# Self-Correcting Johnson Decade Counter

This block counts modulo ten with a five-stage twisted-ring register. Each of the ten ring states drives one active-high output, and exactly one of these outputs is high at a time. An active-low carry, taken from the top stage, is low for the upper half of the count. It can serve as the rising-edge step input of a following counter, so that counters can be chained in ripple fashion.

Two step inputs advance the count, and each one gates the other. Step A advances on a rising edge while step B is low. Step B advances on a falling edge while step A is high. Both inputs are sampled by the system clock through two-flop synchronisers, and edges are taken from the synchronised values. The master reset is asynchronous and overrides everything. Its release is synchronised, so the first step after reset starts from state 0. A modified feedback term into the third stage forces any illegal ring code back into the legal cycle. A load port, meant only for test, writes any code into the ring.

Top module: `jdec_counter`

## Requirements
- R1: The ring (bit 0 = stage 1) steps through 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 as states 0 to 9. In state k, `dec_o[k]` is high and every other bit of `dec_o` is low.
- R2: A low-to-high change of `step_a_i` while `step_b_i` is low advances the count by one state.
- R3: A high-to-low change of `step_b_i` while `step_a_i` is high advances the count by one state.
- R4: No other change has an effect on the count. This covers a rise of A while B is high, a fall of B while A is low, a fall of A, a rise of B, and both inputs rising or both falling together.
- R5: While `mr_i` is high, the count is held at state 0 at once and without waiting for a clock edge: `dec_o` = 0000000001 and `carry_n_o` = 1.
- R6: `carry_n_o` is 0 in states 5 to 9 and 1 in states 0 to 4.
- R7: If A rises and B falls in the same synchronised sample, the count advances by exactly one state.
- R8: When `tst_load_en_i` is high at a clock edge, `tst_load_val_i` (bit 0 = stage 1) is written into the ring, and this takes priority over a step. From each of the 22 illegal codes, the counter is in the legal cycle after at most 11 steps.
- R9: Release of `mr_i` is synchronised. An input level held through the release does not produce a step, and the first real step moves the count from state 0 to state 1.
- R10: The count wraps from state 9 to state 0 on the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the step inputs |
| mr_i | input | 1 | Asynchronous master reset, active high |
| step_a_i | input | 1 | Step input, acts on its rising edge while B is low |
| step_b_i | input | 1 | Step input, acts on its falling edge while A is high |
| tst_load_en_i | input | 1 | Test-only load strobe for the ring |
| tst_load_val_i | input | 5 | Test-only ring code, bit 0 = stage 1 |
| dec_o | output | 10 | One-hot decoded state, bit k = state k |
| carry_n_o | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
The table walks every pairing of edges between the two step inputs, including the ones that must be ignored. A design that gated each input on the wrong level, or on the wrong edge, would advance on a non-qualifying change or miss a qualifying one. The change from (A low, B high) to (A high, B low) makes both inputs qualify in one sample; a design that added the two steps would skip a state. A reset released with A already high catches a design whose edge history restarts at zero, because that design would count a phantom step. Every one of the 22 illegal codes is loaded and then stepped. A feedback fix that is too weak would leave a code in a parasitic cycle, and one that is too strong would break a legal transition.

// File: rtl/jdec_pkg.sv
package jdec_pkg;
    localparam int STAGES     = 5;
    localparam int NOUT       = 2 * STAGES;
    localparam int SYNC_DEPTH = 2;
    localparam int HOLD_LEN   = SYNC_DEPTH + 1;

    typedef struct packed {
        logic a_p;
        logic b_p;
    } edge_st_t;
endpackage

// File: rtl/jdec_sync.sv
module jdec_sync #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = in_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) pipe_q <= '0;
        else       pipe_q <= pipe_d;
    end

    assign out_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/jdec_rst_hold.sv
module jdec_rst_hold #(
    parameter int LEN = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic hold_o
);
    logic [LEN-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = {hold_q[LEN-2:0], 1'b0};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) hold_q <= '1;
        else       hold_q <= hold_d;
    end

    assign hold_o = hold_q[LEN-1];
endmodule

// File: rtl/jdec_adv.sv
module jdec_adv
    import jdec_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic hold_i,
    input  logic a_s_i,
    input  logic b_s_i,
    output logic adv_o
);
    edge_st_t st_d, st_q;
    logic     rise_a, fall_b;

    always_comb begin
        st_d.a_p = a_s_i;
        st_d.b_p = b_s_i;
        rise_a   = a_s_i & ~st_q.a_p & ~b_s_i;
        fall_b   = ~b_s_i & st_q.b_p & a_s_i;
        adv_o    = ~hold_i & (rise_a | fall_b);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end
endmodule

// File: rtl/jdec_ring.sv
module jdec_ring #(
    parameter int N = 5
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         adv_i,
    input  logic         load_i,
    input  logic [N-1:0] load_val_i,
    output logic [N-1:0] ring_o
);
    typedef struct packed {
        logic [N-1:0] stg;
    } ring_st_t;

    ring_st_t     r_d, r_q;
    logic [N-1:0] shifted;

    always_comb begin
        shifted    = {r_q.stg[N-2:0], ~r_q.stg[N-1]};
        shifted[2] = r_q.stg[1] & (r_q.stg[0] | r_q.stg[2]);
        r_d        = r_q;
        if (load_i)     r_d.stg = load_val_i;
        else if (adv_i) r_d.stg = shifted;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end

    assign ring_o = r_q.stg;
endmodule

// File: rtl/jdec_decode.sv
module jdec_decode #(
    parameter int N = 5,
    localparam int M = 2 * N
) (
    input  logic [N-1:0] ring_i,
    output logic [M-1:0] dec_o,
    output logic         carry_n_o
);
    for (genvar k = 0; k < M; k++) begin : g_out
        if (k == 0) begin : g_first
            assign dec_o[k] = ~ring_i[N-1] & ~ring_i[0];
        end else if (k < N) begin : g_fill
            assign dec_o[k] = ring_i[k-1] & ~ring_i[k];
        end else if (k == N) begin : g_full
            assign dec_o[k] = ring_i[N-1] & ring_i[0];
        end else begin : g_drain
            assign dec_o[k] = ~ring_i[k-N-1] & ring_i[k-N];
        end
    end

    assign carry_n_o = ~ring_i[N-1];
endmodule

// File: rtl/jdec_counter.sv
module jdec_counter
    import jdec_pkg::*;
(
    input  logic              clk_i,
    input  logic              mr_i,
    input  logic              step_a_i,
    input  logic              step_b_i,
    input  logic              tst_load_en_i,
    input  logic [STAGES-1:0] tst_load_val_i,
    output logic [NOUT-1:0]   dec_o,
    output logic              carry_n_o
);
    logic [1:0]        steps_s;
    logic              hold;
    logic              adv;
    logic [STAGES-1:0] ring_q;

    jdec_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk_i (clk_i),
        .rst_i (mr_i),
        .in_i  ({step_b_i, step_a_i}),
        .out_o (steps_s)
    );

    jdec_rst_hold #(.LEN(HOLD_LEN)) u_hold (
        .clk_i  (clk_i),
        .rst_i  (mr_i),
        .hold_o (hold)
    );

    jdec_adv u_adv (
        .clk_i  (clk_i),
        .rst_i  (mr_i),
        .hold_i (hold),
        .a_s_i  (steps_s[0]),
        .b_s_i  (steps_s[1]),
        .adv_o  (adv)
    );

    jdec_ring #(.N(STAGES)) u_ring (
        .clk_i      (clk_i),
        .rst_i      (mr_i),
        .adv_i      (adv),
        .load_i     (tst_load_en_i),
        .load_val_i (tst_load_val_i),
        .ring_o     (ring_q)
    );

    jdec_decode #(.N(STAGES)) u_dec (
        .ring_i    (ring_q),
        .dec_o     (dec_o),
        .carry_n_o (carry_n_o)
    );
endmodule

// File: rtl/jdec_counter_chk.sv
module jdec_counter_chk #(
    parameter int N = 5,
    parameter int M = 10
) (
    input logic         clk_i,
    input logic         mr_i,
    input logic         adv_i,
    input logic         load_i,
    input logic [N-1:0] ring_i,
    input logic [M-1:0] dec_i,
    input logic         carry_n_i
);
    function automatic logic thermo(input logic [N-1:0] r);
        logic [N-1:0] nr;
        nr = ~r;
        return ((r & (r + N'(1))) == '0) || ((nr & (nr + N'(1))) == '0);
    endfunction

    logic legal;
    assign legal = thermo(ring_i);

    always @(posedge clk_i) begin
        if (mr_i) begin
            AST_RESET_ZERO: assert (ring_i == '0 && dec_i == M'(1) && carry_n_i); // R5
        end
    end

    AST_LEGAL_ONEHOT: assert property (@(posedge clk_i) disable iff (mr_i)
        legal |-> $onehot(dec_i)); // R1

    AST_CARRY_UPPER: assert property (@(posedge clk_i) disable iff (mr_i)
        legal |-> (carry_n_i == ~|dec_i[M-1:N])); // R6

    AST_STEP_ROTATE: assert property (@(posedge clk_i) disable iff (mr_i)
        (adv_i && !load_i && legal) |=> (dec_i == {$past(dec_i[M-2:0]), $past(dec_i[M-1])})); // R10

    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (mr_i)
        (!adv_i && !load_i) |=> $stable(ring_i)); // R4
endmodule

bind jdec_counter jdec_counter_chk #(.N(jdec_pkg::STAGES), .M(jdec_pkg::NOUT)) u_chk (
    .clk_i     (clk_i),
    .mr_i      (mr_i),
    .adv_i     (adv),
    .load_i    (tst_load_en_i),
    .ring_i    (ring_q),
    .dec_i     (dec_o),
    .carry_n_i (carry_n_o)
);

// File: tb/jdec_counter_tb.sv
module jdec_counter_tb;
    logic       clk = 1'b0;
    logic       mr = 1'b1;
    logic       sa = 1'b0;
    logic       sb = 1'b0;
    logic       ld = 1'b0;
    logic [4:0] ldv = '0;
    logic [9:0] dec;
    logic       carry_n;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    jdec_counter u_dut (
        .clk_i          (clk),
        .mr_i           (mr),
        .step_a_i       (sa),
        .step_b_i       (sb),
        .tst_load_en_i  (ld),
        .tst_load_val_i (ldv),
        .dec_o          (dec),
        .carry_n_o      (carry_n)
    );

    typedef struct packed {
        logic       a;
        logic       b;
        logic [3:0] idx;
    } vec_t;

    localparam int NVEC = 28;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 4'd1},  // R2 rise A, B low
        '{1'b0, 1'b0, 4'd1},  // R4 fall A
        '{1'b1, 1'b0, 4'd2},  // R2
        '{1'b1, 1'b1, 4'd2},  // R4 rise B
        '{1'b1, 1'b0, 4'd3},  // R3 fall B, A high
        '{1'b0, 1'b0, 4'd3},  // R4
        '{1'b0, 1'b1, 4'd3},  // R4
        '{1'b1, 1'b1, 4'd3},  // R4 rise A with B high
        '{1'b0, 1'b1, 4'd3},  // R4
        '{1'b0, 1'b0, 4'd3},  // R4 fall B with A low
        '{1'b1, 1'b1, 4'd3},  // R4 both rise
        '{1'b0, 1'b0, 4'd3},  // R4 both fall
        '{1'b1, 1'b0, 4'd4},  // R2
        '{1'b1, 1'b1, 4'd4},  // R4
        '{1'b0, 1'b0, 4'd4},  // R4 both fall, A low
        '{1'b0, 1'b1, 4'd4},  // R4
        '{1'b1, 1'b0, 4'd5},  // R7 both qualify, one step
        '{1'b0, 1'b0, 4'd5},
        '{1'b1, 1'b0, 4'd6},  // R6 upper half
        '{1'b0, 1'b0, 4'd6},
        '{1'b1, 1'b0, 4'd7},
        '{1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b0, 4'd8},
        '{1'b0, 1'b0, 4'd8},
        '{1'b1, 1'b0, 4'd9},
        '{1'b0, 1'b0, 4'd9},
        '{1'b1, 1'b0, 4'd0},  // R10 wrap
        '{1'b0, 1'b0, 4'd0}
    };

    function automatic logic [4:0] jcode(input int k);
        if (k <= 5) return 5'((1 << k) - 1);
        return 5'((31 << (k - 5)) & 31);
    endfunction

    function automatic bit is_legal(input logic [4:0] v);
        for (int k = 0; k < 10; k++) begin
            if (jcode(k) == v) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check_state(input int idx, input string tag);
        logic [9:0] exp_dec;
        logic       exp_c;
        exp_dec = 10'(1 << idx);
        exp_c   = (idx < 5);
        n_chk++;
        if (dec !== exp_dec || carry_n !== exp_c) begin
            n_err++;
            $display("FAIL %s: dec=%b carry_n=%b expected dec=%b carry_n=%b",
                     tag, dec, carry_n, exp_dec, exp_c);
        end
    endtask

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        sa = a;
        sb = b;
        repeat (5) @(negedge clk);
    endtask

    task automatic step_once();
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    task automatic load(input logic [4:0] v);
        @(negedge clk);
        ld  = 1'b1;
        ldv = v;
        @(negedge clk);
        ld  = 1'b0;
        @(negedge clk);
    endtask

    function automatic int find_idx(input logic [9:0] d);
        for (int k = 0; k < 10; k++) begin
            if (d == 10'(1 << k)) return k;
        end
        return -1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_err++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_state(0, "R5 reset state");
        mr = 1'b0;
        repeat (5) @(negedge clk);
        check_state(0, "R9 after release");

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].a, VEC[i].b);
            check_state(int'(VEC[i].idx), $sformatf("R1/R2/R3/R4 vector %0d", i));
        end

        // R5: asynchronous assertion mid-count
        step_once();
        step_once();
        step_once();
        check_state(3, "R2 pre-reset count");
        @(negedge clk);
        mr = 1'b1;
        #1;
        check_state(0, "R5 immediate reset");
        sa = 1'b1;
        repeat (4) @(negedge clk);
        sa = 1'b0;
        repeat (4) @(negedge clk);
        sa = 1'b1;
        repeat (4) @(negedge clk);
        check_state(0, "R5 held under toggling");

        // R9: A held high across release must not step
        mr = 1'b0;
        repeat (8) @(negedge clk);
        check_state(0, "R9 no phantom step");
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        check_state(1, "R9 first step");
        drive(1'b0, 1'b0);

        // R8: legal load through test port
        load(5'b00111);
        check_state(3, "R8 legal load");
        load(5'b11000);
        check_state(8, "R8 legal load upper");

        // R8: recovery from each illegal code
        for (int v = 0; v < 32; v++) begin
            if (!is_legal(5'(v))) begin
                int  idx;
                bit  bad;
                load(5'(v));
                repeat (11) step_once();
                idx = find_idx(dec);
                bad = (idx < 0) || (carry_n !== (idx < 5));
                for (int s = 0; s < 10 && !bad; s++) begin
                    step_once();
                    idx = (idx + 1) % 10;
                    if (dec !== 10'(1 << idx) || carry_n !== (idx < 5)) bad = 1'b1;
                end
                n_chk++;
                if (bad) begin
                    n_err++;
                    $display("FAIL R8 code %b: dec=%b carry_n=%b expected one-hot ring sequence",
                             5'(v), dec, carry_n);
                end
            end
        end

        finish_run();
    end
endmodule